// File: doc/BRIEF.md
# Multicast Benes Distribution Network

This block delivers a row of operands from LANES source slots to LANES destination slots, the multiplier-side buffers of a dot-product engine, in one pass through a multistage switch fabric. The fabric has 2·log2(LANES)−1 columns of links. Every column holds one switching node per lane. The hop distance of a column shrinks from LANES/2 down to 1 across the front half and grows back to LANES/2 across the back half. Each node has two independent enables. One forwards its operand to the same lane in the next column (the straight path). The other forwards it to the partner lane at that column's hop distance (the diagonal path). Setting both enables copies an operand onto two lanes, so one source can fan out to many destinations in a single traversal and is read only once.

Node enables are loaded as one vector into a configuration register and stay held while data streams through. The switch columns are purely combinational. A single register at the output gives one cycle from operand to destination. Each destination slot also carries a valid flag: a slot that no source reaches reads zero with its flag low. Working out the enable vector for a mapping belongs to the surrounding control logic.

Top module: `benes_mcast_net`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every `dst_vld` bit and every `dst_data` lane is zero. Reset clears the configuration register, so outputs stay invalid until a configuration is loaded. A configuration of all zeros also yields no valid output.
- R2: When `cfg_load` is high at a clock edge, `cfg_bits` is captured at that edge. Operands presented at that same edge are still routed with the previously held configuration. The new configuration applies from the next edge onward.
- R3: `dst_data`/`dst_vld` after a clock edge reflect `src_data` sampled at that edge through the held configuration, with exactly one register of latency.
- R4: Column s (0 to 2·log2(LANES)−2) links lane j to lane j XOR D(s), with D(s)=LANES>>(s+1) for s<log2(LANES) and D(s)=1<<(s−log2(LANES)+1) otherwise. Bit (s·LANES+j)·2 enables the straight path of node (s,j) and bit (s·LANES+j)·2+1 enables its diagonal path. Column 0 nodes carry `src_data` lane j (bits j·W upward), and the last column feeds `dst_data` lane j.
- R5: Any mapping dst = src XOR m, routed by fixing the bits of the index difference through the front-half columns, delivers every operand intact to its destination.
- R6: The same XOR mappings routed through the back-half columns (distances 1, 2, …, LANES/2) are delivered intact.
- R7: One source can reach several destinations in one pass, including all LANES destinations at once, and two sources can each fan out to disjoint destination groups in the same pass.
- R8: A destination lane reached by no enabled path reads zero with its valid bit low, whatever the source data.
- R9: When a node receives an operand over its straight link and another over its diagonal link in the same cycle, the straight one is kept.
- R10: With no new load, the held configuration keeps routing across any number of cycles: constant `src_data` gives constant outputs.
- R11: A configuration with every straight enable set and every diagonal enable clear maps each source lane to the same destination lane, with every valid bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture `cfg_bits` into the configuration register |
| cfg_bits | input | 2·LANES·(2·log2(LANES)−1) | Straight and diagonal enables of all nodes |
| src_data | input | LANES·W | Source operands, lane j at bits j·W upward |
| dst_data | output | LANES·W | Destination operands, registered |
| dst_vld | output | LANES | Per-destination valid flag |

## Verification
The bench builds the block with LANES=8 and W=16. This gives five link columns whose front half (distances 4, 2, 1) and back half (1, 2, 4) differ, so routes can be steered through either half and a reload can be checked against operands already in flight. Eight lanes are enough for full broadcast, split fan-out to two groups of four, partial permutations that leave lanes unreached, and a deliberate straight-versus-diagonal collision. The expected lane contents come from each test's destination-to-source map, not from the fabric.

// File: rtl/benes_mc_pkg.sv
package benes_mc_pkg;

    // Position of each enable inside a node's two-bit control field
    typedef enum int {
        CTL_STRAIGHT = 0,
        CTL_DIAG     = 1
    } node_ctl_sel_e;

    localparam int CTL_PER_NODE = 2;

    typedef struct packed {
        logic diag;
        logic straight;
    } node_ctl_t;

    // Number of link columns for a fabric of 2**lanes_log lanes
    function automatic int link_columns(int lanes_log);
        return 2 * lanes_log - 1;
    endfunction

    // Hop distance of a link column: halves across the front, doubles across the back
    function automatic int hop_dist(int lanes_log, int column);
        if (column < lanes_log)
            return 1 << (lanes_log - 1 - column);
        else
            return 1 << (column - lanes_log + 1);
    endfunction

    // Bit offset of a node's control field in the flat configuration vector
    function automatic int ctl_offset(int lanes, int column, int lane);
        return (column * lanes + lane) * CTL_PER_NODE;
    endfunction

endpackage

// File: rtl/mcb_cfg_reg.sv
module mcb_cfg_reg #(
    parameter int CFG_W = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] bits_in,
    output logic [CFG_W-1:0] bits_q
);

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else if (load)
            bits_q <= bits_in;
    end

endmodule

// File: rtl/mcb_merge.sv
// Receiving side of one node: straight arrival has priority over diagonal.
module mcb_merge #(
    parameter int W = 16
) (
    input  logic         st_vld,
    input  logic [W-1:0] st_data,
    input  logic         dg_vld,
    input  logic [W-1:0] dg_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    always_comb begin
        if (st_vld) begin
            out_vld  = 1'b1;
            out_data = st_data;
        end else if (dg_vld) begin
            out_vld  = 1'b1;
            out_data = dg_data;
        end else begin
            out_vld  = 1'b0;
            out_data = '0;
        end
    end

endmodule

// File: rtl/mcb_column.sv
module mcb_column
    import benes_mc_pkg::*;
#(
    parameter int LANES = 8,
    parameter int W     = 16,
    parameter int DIST  = 1
) (
    input  logic [LANES-1:0]              in_vld,
    input  logic [LANES*W-1:0]            in_data,
    input  logic [LANES*CTL_PER_NODE-1:0] ctl,
    output logic [LANES-1:0]              out_vld,
    output logic [LANES*W-1:0]            out_data
);

    node_ctl_t [LANES-1:0] node_ctl;
    assign node_ctl = ctl;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int PARTNER = j ^ DIST;
        logic st_vld;
        logic dg_vld;

        assign st_vld = in_vld[j]       & node_ctl[j].straight;
        assign dg_vld = in_vld[PARTNER] & node_ctl[PARTNER].diag;

        mcb_merge #(.W(W)) u_merge (
            .st_vld   (st_vld),
            .st_data  (in_data[j*W +: W]),
            .dg_vld   (dg_vld),
            .dg_data  (in_data[PARTNER*W +: W]),
            .out_vld  (out_vld[j]),
            .out_data (out_data[j*W +: W])
        );
    end

endmodule

// File: rtl/benes_mcast_net.sv
module benes_mcast_net
    import benes_mc_pkg::*;
#(
    parameter  int LANES  = 8,
    parameter  int W      = 16,
    localparam int LOG_L  = $clog2(LANES),
    localparam int NCOL   = 2 * LOG_L - 1,
    localparam int COL_CW = LANES * CTL_PER_NODE,
    localparam int CFG_W  = NCOL * COL_CW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [CFG_W-1:0]   cfg_bits,
    input  logic [LANES*W-1:0] src_data,
    output logic [LANES*W-1:0] dst_data,
    output logic [LANES-1:0]   dst_vld
);

    logic [CFG_W-1:0]   cfg_q;
    logic [LANES-1:0]   col_vld  [NCOL+1];
    logic [LANES*W-1:0] col_data [NCOL+1];

    mcb_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .bits_in (cfg_bits),
        .bits_q  (cfg_q)
    );

    assign col_vld[0]  = '1;
    assign col_data[0] = src_data;

    for (genvar s = 0; s < NCOL; s++) begin : g_col
        mcb_column #(
            .LANES (LANES),
            .W     (W),
            .DIST  (hop_dist(LOG_L, s))
        ) u_col (
            .in_vld   (col_vld[s]),
            .in_data  (col_data[s]),
            .ctl      (cfg_q[s*COL_CW +: COL_CW]),
            .out_vld  (col_vld[s+1]),
            .out_data (col_data[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_vld  <= '0;
            dst_data <= '0;
        end else begin
            dst_vld  <= col_vld[NCOL];
            dst_data <= col_data[NCOL];
        end
    end

endmodule

// File: rtl/benes_mcast_chk.sv
module benes_mcast_chk
    import benes_mc_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int W     = 16,
    localparam int LOG_L = $clog2(LANES),
    localparam int CFG_W = (2 * LOG_L - 1) * LANES * CTL_PER_NODE
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_load,
    input logic [CFG_W-1:0]   cfg_bits,
    input logic [LANES*W-1:0] src_data,
    input logic [LANES*W-1:0] dst_data,
    input logic [LANES-1:0]   dst_vld
);

    function automatic logic [CFG_W-1:0] straight_only();
        logic [CFG_W-1:0] v;
        v = '0;
        for (int i = 0; i < CFG_W / CTL_PER_NODE; i++)
            v[i*CTL_PER_NODE + CTL_STRAIGHT] = 1'b1;
        return v;
    endfunction

    localparam logic [CFG_W-1:0] ALL_STRAIGHT = straight_only();

    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q)
            assert_reset_clear_R1: assert (dst_vld == '0 && dst_data == '0)
                else $error("outputs not cleared after reset");
    end

    assert_zero_cfg_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_bits == '0) |=> ##1 (dst_vld == '0));

    assert_held_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_load) && $stable(src_data)) |=> ($stable(dst_data) && $stable(dst_vld)));

    assert_identity_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_bits == ALL_STRAIGHT) |=> ##1 (dst_vld == '1 && dst_data == $past(src_data)));

    for (genvar i = 0; i < LANES; i++) begin : g_idle
        assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
            !dst_vld[i] |-> (dst_data[i*W +: W] == '0));
    end

endmodule

bind benes_mcast_net benes_mcast_chk #(.LANES(LANES), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_bits (cfg_bits),
    .src_data (src_data),
    .dst_data (dst_data),
    .dst_vld  (dst_vld)
);

// File: tb/benes_mcast_net_bench.sv
module benes_mcast_net_bench;

    localparam int NL     = 8;
    localparam int W      = 16;
    localparam int LOG    = 3;
    localparam int NCOL   = 2 * LOG - 1;
    localparam int CFG_W  = NCOL * NL * 2;
    localparam int NW     = NL * W;
    localparam int CLK_NS = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_load = 1'b0;
    logic [CFG_W-1:0] cfg_bits = '0;
    logic [NW-1:0]    src_data = '0;
    logic [NW-1:0]    dst_data;
    logic [NL-1:0]    dst_vld;

    always #(CLK_NS/2) clk = ~clk;

    benes_mcast_net #(.LANES(NL), .W(W)) u_benes_mcast_net (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_bits (cfg_bits),
        .src_data (src_data),
        .dst_data (dst_data),
        .dst_vld  (dst_vld)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit route_bad = 0;
    bit done = 0;

    int map_act [NL];
    int mp [NL];
    logic [NW-1:0] exp_data = '0;
    logic [NL-1:0] exp_vld  = '0;
    string         exp_tag  = "R1";
    bit            exp_on   = 0;

    // Operand pattern: lane i of pattern k
    function automatic logic [NW-1:0] pat(int k);
        logic [NW-1:0] v;
        for (int i = 0; i < NL; i++)
            v[i*W +: W] = W'(k * 4099 + i * 263 + 17);
        return v;
    endfunction

    // Bit-fixing router on the index difference, front or back half
    function automatic logic [CFG_W-1:0] route(input int m [NL], input bit back);
        logic [CFG_W-1:0] v;
        int occ [NCOL+1][NL];
        v = '0;
        for (int s = 0; s <= NCOL; s++)
            for (int l = 0; l < NL; l++)
                occ[s][l] = -1;
        for (int d = 0; d < NL; d++) begin
            if (m[d] >= 0) begin
                int c;
                c = m[d];
                for (int s = 0; s < NCOL; s++) begin
                    bit fix;
                    int b;
                    fix = back ? (s >= LOG - 1) : (s < LOG);
                    b   = back ? (s - LOG + 1) : (LOG - 1 - s);
                    if (fix && (((c ^ d) >> b) & 1) == 1) begin
                        v[(s*NL + c)*2 + 1] = 1'b1;
                        c = c ^ (1 << b);
                    end else begin
                        v[(s*NL + c)*2] = 1'b1;
                    end
                    if (occ[s+1][c] != -1 && occ[s+1][c] != m[d])
                        route_bad = 1;
                    occ[s+1][c] = m[d];
                end
            end
        end
        return v;
    endfunction

    task automatic compare();
        for (int i = 0; i < NL; i++) begin
            n_cmp++;
            if (dst_vld[i] !== exp_vld[i] || dst_data[i*W +: W] !== exp_data[i*W +: W]) begin
                n_bad++;
                $display("FAIL %s lane %0d: actual vld=%b data=%h expected vld=%b data=%h",
                         exp_tag, i, dst_vld[i], dst_data[i*W +: W], exp_vld[i], exp_data[i*W +: W]);
            end
        end
    endtask

    // One clock: check last result, drive new inputs, predict their result
    task automatic step(input bit r, input bit ld, input logic [CFG_W-1:0] cb,
                        input int nm [NL], input logic [NW-1:0] din, input string tag);
        @(negedge clk);
        if (exp_on) compare();
        rst      = r;
        cfg_load = ld;
        cfg_bits = cb;
        src_data = din;
        exp_tag  = tag;
        exp_on   = 1;
        for (int i = 0; i < NL; i++) begin
            if (!r && map_act[i] >= 0) begin
                exp_vld[i]         = 1'b1;
                exp_data[i*W +: W] = din[map_act[i]*W +: W];
            end else begin
                exp_vld[i]         = 1'b0;
                exp_data[i*W +: W] = '0;
            end
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NL; i++) map_act[i] = -1;
        end else if (ld) begin
            for (int i = 0; i < NL; i++) map_act[i] = nm[i];
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] cb;
        for (int i = 0; i < NL; i++) begin
            map_act[i] = -1;
            mp[i] = -1;
        end

        // R1: reset state
        for (int k = 0; k < 3; k++) step(1, 0, '0, mp, pat(k), "R1 reset");
        step(0, 0, '0, mp, pat(3), "R1 unloaded");
        step(0, 0, '0, mp, pat(4), "R1 unloaded");

        // R11 identity; R2 same-cycle data still uses the empty config
        for (int i = 0; i < NL; i++) mp[i] = i;
        cb = route(mp, 0);
        step(0, 1, cb, mp, pat(5), "R2 old config");
        for (int k = 6; k < 9; k++) step(0, 0, '0, mp, pat(k), "R11/R3 identity");

        // R5 front-half XOR routes
        for (int m = 1; m < NL; m += 3) begin
            for (int i = 0; i < NL; i++) mp[i] = i ^ m;
            cb = route(mp, 0);
            step(0, 1, cb, mp, pat(10 + m), "R2 reload in flight");
            step(0, 0, '0, mp, pat(20 + m), "R5/R4 front xor");
            step(0, 0, '0, mp, pat(30 + m), "R5/R4 front xor");
        end

        // R6 back-half XOR routes
        for (int m = 2; m < NL; m += 3) begin
            for (int i = 0; i < NL; i++) mp[i] = i ^ m;
            cb = route(mp, 1);
            step(0, 1, cb, mp, pat(40 + m), "R2 reload in flight");
            step(0, 0, '0, mp, pat(50 + m), "R6/R4 back xor");
        end

        // R7 full broadcast of lane 6
        for (int i = 0; i < NL; i++) mp[i] = 6;
        cb = route(mp, 0);
        step(0, 1, cb, mp, pat(60), "R2 reload in flight");
        step(0, 0, '0, mp, pat(61), "R7 broadcast");

        // R7 split fan-out: lane 2 to 0..3, lane 5 to 4..7
        for (int i = 0; i < NL; i++) mp[i] = (i < NL/2) ? 2 : 5;
        cb = route(mp, 0);
        step(0, 1, cb, mp, pat(62), "R2 reload in flight");
        step(0, 0, '0, mp, pat(63), "R7 split fanout");

        // R8 partial map: odd lanes unreached
        for (int i = 0; i < NL; i++) mp[i] = (i % 2 == 0) ? (i ^ 1) : -1;
        cb = route(mp, 1);
        step(0, 1, cb, mp, pat(64), "R2 reload in flight");
        step(0, 0, '0, mp, pat(65), "R8 unreached lanes");
        step(0, 0, '0, mp, ~pat(66), "R8 unreached lanes");

        // R9 collision at column 1 lane 4: straight from lane 4 beats diagonal from lane 0
        for (int i = 0; i < NL; i++) mp[i] = -1;
        mp[4] = 4;
        cb = '0;
        cb[(0*NL + 0)*2 + 1] = 1'b1;
        for (int s = 0; s < NCOL; s++) cb[(s*NL + 4)*2] = 1'b1;
        step(0, 1, cb, mp, pat(70), "R2 reload in flight");
        step(0, 0, '0, mp, pat(71), "R9 straight priority");

        // R10 held config across idle and changing data
        for (int i = 0; i < NL; i++) mp[i] = i ^ 7;
        cb = route(mp, 0);
        step(0, 1, cb, mp, pat(72), "R2 reload in flight");
        for (int k = 0; k < 6; k++) step(0, 0, '0, mp, pat(80 + k / 2), "R10 held config");

        // R1 zero config reload
        for (int i = 0; i < NL; i++) mp[i] = -1;
        step(0, 1, '0, mp, pat(90), "R2 reload in flight");
        step(0, 0, '0, mp, pat(91), "R1 zero config");
        step(0, 0, '0, mp, pat(92), "R1 zero config");

        if (route_bad)
            $display("note: reference router saw a contended node");

        @(negedge clk);
        compare();
        done = 1;
        summary();
        $finish;
    end

endmodule